// File: doc/BRIEF.md
# Asynchronous Byte-Wide Register Read Slave

This block sits on the peripheral side of an asynchronous host bus of the Intel style and serves read cycles only. The host places an address, selects the device with an active-low chip select, and pulses an address-latch strobe. While that strobe is high the address path is transparent; once it drops, the address is frozen for the rest of the cycle. The host then pulls an active-low read strobe. The block fetches the selected byte from a synchronous register-file port, drives it toward the data pads, and pulls an active-low ready output once the byte is stable. The host holds the read strobe low until it sees ready, and the cycle closes when the strobe rises or chip select is released.

Every host control signal passes through a two-flop synchroniser into the system clock, and strobe edges are found on the synchronised copies. The host must therefore hold the address for at least three system clocks after the latch strobe falls, and must keep it stable while that strobe is high. The tri-state buffer itself sits in the pad ring: the block gives a byte value and a drive enable. The register-file port has no back-pressure. One read-enable pulse per cycle presents the latched address, and the byte must be valid on the clock after that pulse. `ACCESS_LAT` sets how many clocks after the detected strobe edge ready is asserted. Its minimum is one.

Top module: `ird_slave`

## Requirements
- R1: After reset, ready is high, the data drive enable is low and no register-file read enable is issued.
- R2: The address is taken from the address input while the synchronised latch strobe is high and held after it falls; later changes on the address input do not alter `rf_addr`.
- R3: During a selected read, `bus_d_oe` is high and `bus_d_out` carries the register-file byte for the latched address when ready is low.
- R4: Ready goes low exactly `ACCESS_LAT + 3` clock cycles after the read strobe falls (two synchroniser flops, one edge register, then the access latency); before that it stays high.
- R5: While ready is low and the strobe is held, ready stays low and the byte on `bus_d_out` does not change.
- R6: When the read strobe returns high, the drive enable drops and ready returns high within four clocks.
- R7: When chip select is released during a cycle, the drive enable drops and ready returns high within four clocks.
- R8: Each selected read cycle produces exactly one single-clock `rf_rd_en` pulse.
- R9: A read strobe that falls while chip select is high produces no read enable, no drive enable and no ready.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_cs_n | input | 1 | Host chip select, active low, asynchronous |
| bus_ale | input | 1 | Host address-latch strobe, high = transparent |
| bus_rd_n | input | 1 | Host read strobe, active low |
| bus_addr | input | ADDR_W (15) | Host address |
| bus_d_out | output | DATA_W (8) | Read byte toward the data pads |
| bus_d_oe | output | 1 | Pad drive enable for the data bus |
| bus_rdy_n | output | 1 | Ready to host, active low |
| rf_addr | output | ADDR_W (15) | Register-file read address (latched) |
| rf_rd_en | output | 1 | Register-file read enable, one pulse per cycle |
| rf_rd_data | input | DATA_W (8) | Register-file byte, valid the clock after `rf_rd_en` |

## Verification
A control state that is stuck or late shows first at the ready pin. The bench counts the exact clock on which ready falls after each strobe edge, so a slip of even one clock in the synchroniser, the edge register or the latency counter shows on the first read. A wrong address register or a capture of the byte in the wrong cycle shows as a wrong byte at the moment ready falls, because the bench moves the address input after the latch strobe and predicts each byte from the latched address. A cycle that fails to close shows within four clocks of the strobe rising or chip select being released, as a drive enable or ready that stays active, and a read enable on an unselected strobe shows in the pulse count of that same cycle.

// File: rtl/ird_pkg.sv
package ird_pkg;
  typedef enum logic [1:0] {
    ST_IDLE   = 2'd0,
    ST_ACCESS = 2'd1,
    ST_READY  = 2'd2
  } rd_state_t;

  // positions of host controls inside the synchroniser vector
  localparam int SYNC_CS  = 0;
  localparam int SYNC_ALE = 1;
  localparam int SYNC_RD  = 2;
  localparam int SYNC_W   = 3;
endpackage

// File: rtl/ird_sync.sv
module ird_sync #(
  parameter int          WIDTH   = 3,
  parameter logic [WIDTH-1:0] RST_VAL = '0
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [WIDTH-1:0] async_in,
  output logic [WIDTH-1:0] sync_out
);
  for (genvar b = 0; b < WIDTH; b++) begin : g_bit
    logic meta_q;
    logic stab_q;
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        meta_q <= RST_VAL[b];
        stab_q <= RST_VAL[b];
      end else begin
        meta_q <= async_in[b];
        stab_q <= meta_q;
      end
    end
    assign sync_out[b] = stab_q;
  end
endmodule

// File: rtl/ird_addr_latch.sv
module ird_addr_latch #(
  parameter int ADDR_W = 15
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              ale_s,
  input  logic [ADDR_W-1:0] addr_in,
  output logic [ADDR_W-1:0] addr_q
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     addr_q <= '0;
    else if (ale_s) addr_q <= addr_in;
  end

  assert_addr_hold_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (!ale_s && !$past(ale_s)) |-> $stable(addr_q));
endmodule

// File: rtl/ird_rd_ctrl.sv
module ird_rd_ctrl
  import ird_pkg::*;
#(
  parameter int DATA_W     = 8,
  parameter int ACCESS_LAT = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cs_s,
  input  logic              rd_s,
  output logic              rf_rd_en,
  input  logic [DATA_W-1:0] rf_rd_data,
  output logic [DATA_W-1:0] d_out,
  output logic              d_oe,
  output logic              rdy_n
);
  localparam int CNT_W = (ACCESS_LAT < 2) ? 1 : $clog2(ACCESS_LAT);
  localparam logic [CNT_W-1:0] CNT_LAST = CNT_W'(ACCESS_LAT - 1);

  rd_state_t         state_q;
  logic [CNT_W-1:0]  cnt_q;
  logic [DATA_W-1:0] hold_q;
  logic              rd_d_q;
  logic              cs_d_q;
  logic              fell;
  logic              start;
  logic              abort;

  assign fell  = rd_d_q & ~rd_s;
  assign abort = rd_s | cs_s;
  assign start = (state_q == ST_IDLE) & fell & ~cs_s;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
      cnt_q   <= '0;
      hold_q  <= '0;
      rd_d_q  <= 1'b1;
      cs_d_q  <= 1'b1;
    end else begin
      rd_d_q <= rd_s;
      cs_d_q <= cs_s;
      unique case (state_q)
        ST_IDLE: begin
          if (start) begin
            state_q <= ST_ACCESS;
            cnt_q   <= '0;
          end
        end
        ST_ACCESS: begin
          if (abort) begin
            state_q <= ST_IDLE;
          end else begin
            if (cnt_q == '0) hold_q <= rf_rd_data;
            if (cnt_q == CNT_LAST) state_q <= ST_READY;
            else                   cnt_q   <= cnt_q + 1'b1;
          end
        end
        ST_READY: begin
          if (abort) state_q <= ST_IDLE;
        end
        default: state_q <= ST_IDLE;
      endcase
    end
  end

  assign rf_rd_en = start;
  assign d_out    = hold_q;
  assign d_oe     = (state_q != ST_IDLE) & ~abort;
  assign rdy_n    = (state_q != ST_READY);

  assert_rdy_after_drive_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (rdy_n == 1'b0 && $past(rdy_n) == 1'b1) |-> $past(d_oe));

  assert_data_stable_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (!rdy_n && !$past(rdy_n)) |-> $stable(d_out));

  assert_rdy_release_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_s && !rd_d_q) |=> rdy_n);

  assert_rdy_release_cs_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (cs_s && !cs_d_q) |=> rdy_n);

  assert_rden_pulse_R8: assert property (@(posedge clk) disable iff (!rst_n)
    rf_rd_en |=> !rf_rd_en);
endmodule

// File: rtl/ird_slave.sv
module ird_slave
  import ird_pkg::*;
#(
  parameter int ADDR_W     = 15,
  parameter int DATA_W     = 8,
  parameter int ACCESS_LAT = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bus_cs_n,
  input  logic              bus_ale,
  input  logic              bus_rd_n,
  input  logic [ADDR_W-1:0] bus_addr,
  output logic [DATA_W-1:0] bus_d_out,
  output logic              bus_d_oe,
  output logic              bus_rdy_n,
  output logic [ADDR_W-1:0] rf_addr,
  output logic              rf_rd_en,
  input  logic [DATA_W-1:0] rf_rd_data
);
  localparam logic [SYNC_W-1:0] SYNC_RST = SYNC_W'(3'b101);

  logic [SYNC_W-1:0] ctl_raw;
  logic [SYNC_W-1:0] ctl_s;

  initial begin
    if (ACCESS_LAT < 1) $error("ACCESS_LAT must be at least 1");
  end

  assign ctl_raw[SYNC_CS]  = bus_cs_n;
  assign ctl_raw[SYNC_ALE] = bus_ale;
  assign ctl_raw[SYNC_RD]  = bus_rd_n;

  ird_sync #(.WIDTH(SYNC_W), .RST_VAL(SYNC_RST)) u_sync (
    .clk      (clk),
    .rst_n    (rst_n),
    .async_in (ctl_raw),
    .sync_out (ctl_s)
  );

  ird_addr_latch #(.ADDR_W(ADDR_W)) u_addr (
    .clk     (clk),
    .rst_n   (rst_n),
    .ale_s   (ctl_s[SYNC_ALE]),
    .addr_in (bus_addr),
    .addr_q  (rf_addr)
  );

  ird_rd_ctrl #(.DATA_W(DATA_W), .ACCESS_LAT(ACCESS_LAT)) u_ctrl (
    .clk        (clk),
    .rst_n      (rst_n),
    .cs_s       (ctl_s[SYNC_CS]),
    .rd_s       (ctl_s[SYNC_RD]),
    .rf_rd_en   (rf_rd_en),
    .rf_rd_data (rf_rd_data),
    .d_out      (bus_d_out),
    .d_oe       (bus_d_oe),
    .rdy_n      (bus_rdy_n)
  );
endmodule

// File: tb/ird_slave_bench.sv
module ird_slave_bench;
  localparam int AW  = 15;
  localparam int DW  = 8;
  localparam int LAT = 3;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          cs_n = 1'b1;
  logic          ale = 1'b0;
  logic          rd_n = 1'b1;
  logic [AW-1:0] addr = '0;
  logic [DW-1:0] d_out;
  logic          d_oe;
  logic          rdy_n;
  logic [AW-1:0] rf_addr;
  logic          rf_rd_en;
  logic [DW-1:0] rf_q = '0;

  int checks = 0;
  int fails  = 0;
  int pulses = 0;
  bit done   = 1'b0;

  always #5 clk = ~clk;

  ird_slave #(.ADDR_W(AW), .DATA_W(DW), .ACCESS_LAT(LAT)) u_ird_slave (
    .clk(clk), .rst_n(rst_n), .bus_cs_n(cs_n), .bus_ale(ale), .bus_rd_n(rd_n),
    .bus_addr(addr), .bus_d_out(d_out), .bus_d_oe(d_oe), .bus_rdy_n(rdy_n),
    .rf_addr(rf_addr), .rf_rd_en(rf_rd_en), .rf_rd_data(rf_q)
  );

  function automatic logic [DW-1:0] rf_val(logic [AW-1:0] a);
    return a[7:0] ^ {1'b0, a[14:8]} ^ 8'h5A;
  endfunction

  // register-file model: byte valid the clock after the read enable
  always @(posedge clk) begin
    if (rf_rd_en) begin
      rf_q <= rf_val(rf_addr);
      pulses <= pulses + 1;
    end
  end

  task automatic chk(input bit ok, input string req, input longint act, input longint exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic do_read(input logic [AW-1:0] a, input bit sel,
                         input bit move_addr, input bit end_by_cs);
    int n;
    int p0;
    logic [DW-1:0] exp_d;
    exp_d = rf_val(a);
    @(negedge clk);
    cs_n = ~sel; addr = a; ale = 1'b1;
    repeat (3) @(negedge clk);
    ale = 1'b0;
    repeat (4) @(negedge clk);
    if (move_addr) addr = ~a;
    p0 = pulses;
    rd_n = 1'b0;
    n = 0;
    if (sel) begin
      for (int i = 1; i <= LAT + 10; i++) begin
        @(negedge clk);
        n = i;
        if (!rdy_n) break;
      end
      chk(n == LAT + 3, "R4 ready latency", n, LAT + 3);
      chk(d_oe == 1'b1 && d_out == exp_d, "R3 read byte", {d_oe, d_out}, {1'b1, exp_d});
      chk(rf_addr == a, "R2 latched address", rf_addr, a);
      chk(pulses - p0 == 1, "R8 read enable count", pulses - p0, 1);
      repeat (3) @(negedge clk);
      chk(!rdy_n && d_oe && d_out == exp_d, "R5 held ready and byte",
          {rdy_n, d_oe, d_out}, {2'b01, exp_d});
      if (end_by_cs) cs_n = 1'b1;
      else           rd_n = 1'b1;
      repeat (4) @(negedge clk);
      if (end_by_cs)
        chk(rdy_n && !d_oe, "R7 cs release", {rdy_n, d_oe}, 2'b10);
      else
        chk(rdy_n && !d_oe, "R6 strobe release", {rdy_n, d_oe}, 2'b10);
      rd_n = 1'b1;
    end else begin
      for (int i = 1; i <= LAT + 6; i++) begin
        @(negedge clk);
        if (!rdy_n || d_oe) n++;
      end
      chk(n == 0, "R9 unselected ready/drive cycles", n, 0);
      chk(pulses - p0 == 0, "R9 unselected read enables", pulses - p0, 0);
      rd_n = 1'b1;
    end
    cs_n = 1'b1;
    repeat (4) @(negedge clk);
  endtask

  initial begin : wdog
    repeat (200000) @(posedge clk);
    if (!done) begin
      fails++;
      checks++;
      $display("FAIL watchdog expired");
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
      $finish;
    end
  end

  initial begin : main
    void'($urandom(32'd20240611));
    repeat (3) @(negedge clk);
    chk(rdy_n && !d_oe && !rf_rd_en, "R1 reset state", {rdy_n, d_oe, rf_rd_en}, 3'b100);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    chk(rdy_n && !d_oe && pulses == 0, "R1 after reset release", {rdy_n, d_oe}, 2'b10);
    // directed corners
    do_read(15'h0000, 1'b1, 1'b0, 1'b0);
    do_read(15'h7FFF, 1'b1, 1'b1, 1'b0);
    do_read(15'h1234, 1'b0, 1'b0, 1'b0);
    do_read(15'h4321, 1'b1, 1'b1, 1'b1);
    do_read(15'h2AAA, 1'b1, 1'b1, 1'b0);
    // constrained random
    for (int k = 0; k < 40; k++) begin
      logic [AW-1:0] ra;
      ra = AW'($urandom);
      do_read(ra, ($urandom % 5) != 0, $urandom % 2 == 1, ($urandom % 4) == 0);
    end
    done = 1'b1;
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end
endmodule